// File: doc/BRIEF.md
# PWM Shadow Register Stage with Update Lockout

This block sits between the software view of a PWM time base and its comparators. Software writes three duty-cycle values and one period value into holding buffers. The comparators read a separate set of active registers. Staged values move from the buffers to the active registers at a period boundary. This lets a group of related changes take effect together at a clean edge of the waveform.

A lockout control input freezes every buffer-to-active transfer. Software can then rewrite several buffers without the comparators ever seeing a partial mix of old and new values. A second control input, immediate update, lets a duty-cycle write reach its active register in the next cycle. It does this even while lockout is set. The period register never takes this fast path.

The write side is a valid/ready stream carrying an address and a data word. The block never applies back-pressure: `wr_ready` is held high, and every cycle with `wr_valid` high completes one write. The lockout bit, the immediate-update bit and the boundary pulse are plain level or pulse controls without a handshake.

Top module: `pwm_shadow_regs`

## Requirements
- R1: After reset, all buffers, active duty registers and the active period read zero.
- R2: A write with `wr_valid` high stores `wr_data` in the buffer selected by `wr_addr`: addresses 0, 1 and 2 select duty slots 0, 1 and 2, and address 3 selects the period. Without a boundary or immediate update, the active outputs do not change.
- R3: When `boundary` is high and `lock` is low, all four active registers load their buffer contents on the same clock edge. The new values are visible in the next cycle.
- R4: While `lock` is high, a boundary pulse leaves all four active registers unchanged.
- R5: When `imm_upd` is high, a write to duty address 0 to 2 appears on that active duty output in the next cycle, whatever the value of `lock`.
- R6: `imm_upd` has no effect on writes to the period address. The period only changes through a boundary transfer with `lock` low.
- R7: Lowering `lock` does not start a transfer by itself. Pending values move at the next boundary pulse.
- R8: A write in the same cycle as a boundary transfer is captured in the buffer. The transfer carries the buffer's previous value, and the new value takes effect at the following boundary.
- R9: An immediate duty write that coincides with a boundary transfer places the newly written data, not the old buffer value, in that active duty register.
- R10: `wr_ready` is high in every cycle after reset, so the write stream never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | ADDR_W (2) | Target buffer: 0 to 2 duty, 3 period |
| wr_data | input | W (16) | Value to store |
| lock | input | 1 | Update lockout: blocks boundary transfers |
| imm_upd | input | 1 | Immediate update for duty writes |
| boundary | input | 1 | One-cycle period-boundary pulse |
| duty_act | output | N_DUTY*W (48) | Active duty values, slot k in bits [k*W +: W] |
| period_act | output | W (16) | Active period value |

## Verification
On every cycle, the assertions check the following:
- Each active register holds its value when no transfer or immediate write reaches it.
- A boundary with lockout low copies the previous buffer value.
- An immediate duty write lands in one cycle.
- A period write under immediate update leaves the period untouched.
- Each accepted write lands in its buffer.

Some behaviours depend on history and can only be shown by the bench's scenarios:
- Clearing lockout does not transfer on its own.
- Values staged over many cycles arrive together at one boundary.
- Immediate-update data wins over a coincident transfer.

The bench compares these scenarios with a behavioural model on every clock.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  typedef enum logic {
    SLOT_DUTY   = 1'b0,
    SLOT_PERIOD = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/pwm_shadow_decode.sv
module pwm_shadow_decode #(
  parameter int N_SLOT = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [N_SLOT-1:0] hit
);
  always_comb begin
    hit = '0;
    for (int k = 0; k < N_SLOT; k++) begin
      if (wr_valid && (int'(wr_addr) == k)) hit[k] = 1'b1;
    end
  end

  // R2: at most one buffer selected, and one selected for every in-range write
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (int'(wr_addr) < N_SLOT)) |-> $countones(hit) == 1);
  a_r2_no_stray_target: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> hit == '0);
endmodule

// File: rtl/pwm_shadow_slot.sv
module pwm_shadow_slot
  import pwm_shadow_pkg::*;
#(
  parameter int         W    = 16,
  parameter slot_kind_e KIND = SLOT_DUTY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         lock,
  input  logic         imm_upd,
  input  logic         boundary,
  output logic [W-1:0] act_q
);
  logic [W-1:0] buf_q;
  logic         xfer;
  logic         fast;

  assign xfer = boundary && !lock;

  generate
    if (KIND == SLOT_DUTY) begin : g_duty
      assign fast = wr_hit && imm_upd;
    end else begin : g_period
      assign fast = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_hit) begin
      buf_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (fast) begin
      act_q <= wr_data;
    end else if (xfer) begin
      act_q <= buf_q;
    end
  end

  // R2: accepted write lands in the buffer
  a_r2_buffer_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> buf_q == $past(wr_data));
  // R2: no transfer, no immediate write -> active holds
  a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !(wr_hit && imm_upd && KIND == SLOT_DUTY)) |=> $stable(act_q));
  // R4: lockout freezes the active register
  a_r4_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !(wr_hit && imm_upd && KIND == SLOT_DUTY)) |=> $stable(act_q));
  // R3 / R8: boundary copies the previous buffer content
  a_r3_boundary_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !lock && !(wr_hit && imm_upd)) |=> act_q == $past(buf_q));
  // R5 / R9: immediate duty write arrives next cycle
  a_r5_immediate_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SLOT_DUTY && wr_hit && imm_upd) |=> act_q == $past(wr_data));
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_DUTY = 3,
  localparam int N_SLOT = N_DUTY + 1,
  localparam int ADDR_W = $clog2(N_SLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic                lock,
  input  logic                imm_upd,
  input  logic                boundary,
  output logic [N_DUTY*W-1:0] duty_act,
  output logic [W-1:0]        period_act
);
  logic [N_SLOT-1:0] hit;

  // R10: the write stream is never stalled
  assign wr_ready = 1'b1;

  pwm_shadow_decode #(.N_SLOT(N_SLOT), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .hit(hit)
  );

  generate
    for (genvar k = 0; k < N_DUTY; k++) begin : g_duty_slot
      pwm_shadow_slot #(.W(W), .KIND(SLOT_DUTY)) u_slot (
        .clk(clk), .rst_n(rst_n), .wr_hit(hit[k]), .wr_data(wr_data),
        .lock(lock), .imm_upd(imm_upd), .boundary(boundary),
        .act_q(duty_act[k*W +: W])
      );
    end
  endgenerate

  pwm_shadow_slot #(.W(W), .KIND(SLOT_PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit[N_DUTY]), .wr_data(wr_data),
    .lock(lock), .imm_upd(imm_upd), .boundary(boundary),
    .act_q(period_act)
  );

  // R6: a period write under immediate update alone leaves the period alone
  a_r6_period_no_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[N_DUTY] && imm_upd && !boundary) |=> $stable(period_act));
  // R10
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/pwm_shadow_regs_test.sv
module pwm_shadow_regs_test;
  localparam int W = 16;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic lock = 1'b0;
  logic imm_upd = 1'b0;
  logic boundary = 1'b0;
  logic [ND*W-1:0] duty_act;
  logic [W-1:0] period_act;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  int m_buf [4];
  int m_act [4];

  always #4 clk = ~clk;

  pwm_shadow_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .lock(lock), .imm_upd(imm_upd),
    .boundary(boundary), .duty_act(duty_act), .period_act(period_act)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_buf[i]) begin m_buf[i] = 0; m_act[i] = 0; end
    end else begin
      int nb [4];
      int na [4];
      nb = m_buf; na = m_act;
      if (boundary && !lock) na = m_buf;
      if (wr_valid && imm_upd && wr_addr < 3) na[wr_addr] = int'(wr_data);
      if (wr_valid) nb[wr_addr] = int'(wr_data);
      m_buf = nb; m_act = na;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, sampled 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int k = 0; k < ND; k++)
        chk(cur_req, int'(duty_act[k*W +: W]), m_act[k], $sformatf("duty%0d", k));
      chk(cur_req, int'(period_act), m_act[3], "period");
      chk("R10", int'(wr_ready), 1, "wr_ready");
    end
  end

  task automatic step(input bit v, input int a, input int d, input bit b,
                      input bit lk, input bit im);
    @(negedge clk);
    wr_valid = v; wr_addr = 2'(a); wr_data = W'(d);
    boundary = b; lock = lk; imm_upd = im;
  endtask

  task automatic idle(input int n, input bit lk, input bit im);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, lk, im);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(duty_act), 0, "duty after reset");
    chk("R1", int'(period_act), 0, "period after reset");

    cur_req = "R2";
    step(1, 0, 16'h0111, 0, 0, 0);
    step(1, 1, 16'h0222, 0, 0, 0);
    step(1, 2, 16'h0333, 0, 0, 0);
    step(1, 3, 16'h1000, 0, 0, 0);
    idle(3, 0, 0);
    chk("R2", int'(period_act), 0, "period before boundary");

    cur_req = "R3";
    step(0, 0, 0, 1, 0, 0);
    idle(2, 0, 0);
    chk("R3", int'(period_act), 16'h1000, "period after boundary");

    cur_req = "R4";
    step(1, 0, 16'h0AAA, 0, 1, 0);
    step(1, 3, 16'h2000, 0, 1, 0);
    step(0, 0, 0, 1, 1, 0);
    idle(2, 1, 0);
    chk("R4", int'(duty_act[W-1:0]), 16'h0111, "duty0 under lock");

    cur_req = "R7";
    idle(3, 0, 0);
    chk("R7", int'(period_act), 16'h1000, "period after unlock");
    step(0, 0, 0, 1, 0, 0);
    idle(2, 0, 0);
    chk("R7", int'(period_act), 16'h2000, "period at next boundary");

    cur_req = "R5";
    step(1, 1, 16'h0BBB, 0, 1, 1);
    idle(1, 1, 1);
    chk("R5", int'(duty_act[W +: W]), 16'h0BBB, "duty1 immediate under lock");

    cur_req = "R6";
    step(1, 3, 16'h3000, 0, 0, 1);
    idle(3, 0, 1);
    chk("R6", int'(period_act), 16'h2000, "period ignores immediate");
    step(0, 0, 0, 1, 0, 0);
    idle(1, 0, 0);
    chk("R6", int'(period_act), 16'h3000, "period via boundary");

    cur_req = "R8";
    step(1, 0, 16'h0CCC, 0, 0, 0);
    step(1, 0, 16'h0DDD, 1, 0, 0);
    idle(1, 0, 0);
    chk("R8", int'(duty_act[W-1:0]), 16'h0CCC, "duty0 old buffer");
    step(0, 0, 0, 1, 0, 0);
    idle(1, 0, 0);
    chk("R8", int'(duty_act[W-1:0]), 16'h0DDD, "duty0 following boundary");

    cur_req = "R9";
    step(1, 2, 16'h0EEE, 0, 0, 0);
    step(1, 2, 16'h0FFF, 1, 0, 1);
    idle(1, 0, 0);
    chk("R9", int'(duty_act[2*W +: W]), 16'h0FFF, "duty2 immediate wins");

    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[0], r[3:2], $urandom, r[5:4] == 2'b00, r[7:6] == 2'b11, r[9:8] == 2'b10);
    end
    idle(3, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule